// File: doc/BRIEF.md
# Byte-Serial Prefix Front End for 64-bit Instruction Decode

This stage sits at the head of a variable-length instruction decoder. It takes one instruction byte per accepted handshake. It collects every legacy prefix byte and any REX byte until the first byte that is not a prefix. That byte is the opcode. The cycle after the opcode is accepted, the stage presents a one-cycle result. The result holds the effective segment override, operand-size state, lock, repeat class, mandatory-prefix class, REX bits, branch hints and the opcode's byte offset. The stage then clears itself for the next instruction.

A mode input selects 64-bit behaviour. In that mode, the four legacy segment overrides (ES, CS, SS, DS) are counted as prefixes but do not change the effective segment. FS and GS still apply. Bytes 40h to 4Fh are REX prefixes in 64-bit mode. A REX byte is only kept if nothing but the opcode follows it. Outside 64-bit mode the same bytes are opcodes. A later stage supplies a branch flag together with the opcode byte, and the CS/DS bytes are then reported as branch hints. A run of prefixes that reaches the instruction length limit ends at once with a fault.

Top module: `pfx_front_decoder`

## Requirements
- R1: `in_ready` is high in every cycle except the one in which `out_valid` is high. `out_valid` pulses for exactly one cycle, in the cycle after the terminating byte is accepted. The result fields hold their value after the pulse until the next result.
- R2: The prefix bytes are 26h, 2Eh, 36h, 3Eh, 64h, 65h, 66h, 67h, F0h, F2h and F3h, plus 40h–4Fh when in 64-bit mode. Every other byte is the opcode. `out_count` equals the number of prefix bytes before the opcode, which is the opcode's offset. `out_opcode` returns the opcode byte. Byte 67h is counted and has no other effect.
- R3: Outside 64-bit mode, the last segment prefix seen sets `out_seg`. The codes are 0 none, 1 ES (26h), 2 CS (2Eh), 3 SS (36h), 4 DS (3Eh), 5 FS (64h), 6 GS (65h).
- R4: In 64-bit mode, only 64h and 65h change `out_seg`, and the last of them wins. The bytes 26h, 2Eh, 36h and 3Eh leave it untouched, so 64h 2Eh 65h 3Eh gives 6 (GS) and 2Eh alone gives 0.
- R5: When `is_branch` is high with the opcode byte, the last of 2Eh/3Eh seen gives `out_hint_nt` (2Eh) or `out_hint_tk` (3Eh). Both outputs are 0 for non-branches or when neither byte is present.
- R6: `out_notrack` is 1 when `is_branch` is high and at least one 3Eh byte was seen. Otherwise it is 0.
- R7: In 64-bit mode, a REX byte sets `out_rex_w/r/x/b` from its bits 3/2/1/0 only if no legacy prefix follows it. A later REX byte replaces an earlier one, and a legacy prefix after a REX byte clears all four bits.
- R8: Outside 64-bit mode, a byte 40h–4Fh ends the prefix run as the opcode, and all four REX outputs are 0.
- R9: `out_opsz` is 1 when a 66h byte was seen. `out_len_chg` (shortened immediate) is 1 when 66h was seen and the effective REX W bit is 0.
- R10: `out_lock` is 1 when F0h was seen. `out_rep` follows the last of F2h/F3h: 0 none, 1 F3h, 2 F2h.
- R11: `out_mp` is the mandatory-prefix class. It is 2 if the last repeat byte is F3h. It is 4 if it is F2h and 66h was also seen, and 3 if F2h alone. It is 1 for 66h with no repeat byte, and 0 otherwise.
- R12: When the fifteenth prefix byte is accepted (MAX_LEN), the run ends at once with `out_fault` = 1 and `out_count` = 15. A run of 14 prefixes followed by an opcode ends with `out_fault` = 0.
- R13: After reset, `out_valid` is 0, `in_ready` is 1, and `out_count` and `out_seg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be taken |
| mode64 | input | 1 | 64-bit mode |
| is_branch | input | 1 | Opcode is a branch, valid with the opcode byte |
| out_valid | output | 1 | Result pulse |
| out_opcode | output | 8 | Terminating byte |
| out_count | output | 4 (CNT_W) | Prefix count / opcode offset |
| out_fault | output | 1 | Length limit reached |
| out_seg | output | 3 | Effective segment code |
| out_opsz | output | 1 | 66h seen |
| out_len_chg | output | 1 | Immediate shortened |
| out_lock | output | 1 | F0h seen |
| out_rep | output | 2 | Repeat class |
| out_mp | output | 3 | Mandatory-prefix class |
| out_rex_w | output | 1 | REX W |
| out_rex_r | output | 1 | REX R |
| out_rex_x | output | 1 | REX X |
| out_rex_b | output | 1 | REX B |
| out_hint_tk | output | 1 | Taken hint |
| out_hint_nt | output | 1 | Not-taken hint |
| out_notrack | output | 1 | No-track marker |

## Verification
The bench builds the block with its defaults: a 15-byte limit and 64-bit support enabled. It sweeps every ordered pair drawn from fifteen prefix-candidate bytes in front of an opcode, in both modes and with the branch flag low and high. This covers every REX-then-legacy and legacy-then-REX ordering, every pair of competing segment, hint and repeat bytes, and the 40h–4Fh opcode case outside 64-bit mode. Directed runs add the four-byte FS/CS/GS/DS mix, the 14- and 15-prefix length boundary, and the hold-and-ready behaviour around a result pulse.

// File: rtl/pfxd_pkg.sv
package pfxd_pkg;

   typedef enum logic [2:0] {
      K_OPC, K_SEG, K_OSZ, K_ASZ, K_LOCK, K_REP, K_REX
   } byte_kind_e;

   localparam logic [2:0] SEG_NONE = 3'd0;
   localparam logic [2:0] SEG_ES   = 3'd1;
   localparam logic [2:0] SEG_CS   = 3'd2;
   localparam logic [2:0] SEG_SS   = 3'd3;
   localparam logic [2:0] SEG_DS   = 3'd4;
   localparam logic [2:0] SEG_FS   = 3'd5;
   localparam logic [2:0] SEG_GS   = 3'd6;

   localparam logic [1:0] HINT_NONE = 2'd0;
   localparam logic [1:0] HINT_NT   = 2'd1;
   localparam logic [1:0] HINT_TK   = 2'd2;

   localparam logic [1:0] REP_NONE = 2'd0;
   localparam logic [1:0] REP_F3   = 2'd1;
   localparam logic [1:0] REP_F2   = 2'd2;

   localparam logic [2:0] MP_NONE = 3'd0;
   localparam logic [2:0] MP_66   = 3'd1;
   localparam logic [2:0] MP_F3   = 3'd2;
   localparam logic [2:0] MP_F2   = 3'd3;
   localparam logic [2:0] MP_66F2 = 3'd4;

   typedef struct packed {
      logic [2:0] seg;
      logic [1:0] hint;
      logic       nt;
      logic       osz;
      logic       lock;
      logic [1:0] rep;
      logic       rex_v;
      logic [3:0] rex;
   } pfx_state_t;

   typedef struct packed {
      logic [2:0] seg;
      logic       opsz;
      logic       len_chg;
      logic       lock;
      logic [1:0] rep;
      logic [2:0] mp;
      logic [3:0] rex;
      logic       hint_tk;
      logic       hint_nt;
      logic       notrack;
   } pfx_result_t;

endpackage

// File: rtl/pfxd_classify.sv
module pfxd_classify
   import pfxd_pkg::*;
(
   input  logic [7:0]  byte_i,
   input  logic        rex_ok_i,
   output byte_kind_e  kind_o,
   output logic [2:0]  seg_o
);

   always_comb begin
      kind_o = K_OPC;
      seg_o  = SEG_NONE;
      case (byte_i)
         8'h26: begin kind_o = K_SEG; seg_o = SEG_ES; end
         8'h2E: begin kind_o = K_SEG; seg_o = SEG_CS; end
         8'h36: begin kind_o = K_SEG; seg_o = SEG_SS; end
         8'h3E: begin kind_o = K_SEG; seg_o = SEG_DS; end
         8'h64: begin kind_o = K_SEG; seg_o = SEG_FS; end
         8'h65: begin kind_o = K_SEG; seg_o = SEG_GS; end
         8'h66: kind_o = K_OSZ;
         8'h67: kind_o = K_ASZ;
         8'hF0: kind_o = K_LOCK;
         8'hF2, 8'hF3: kind_o = K_REP;
         default: begin
            if (rex_ok_i && byte_i[7:4] == 4'h4) kind_o = K_REX;
         end
      endcase
   end

endmodule

// File: rtl/pfxd_accum.sv
module pfxd_accum
   import pfxd_pkg::*;
#(
   parameter int MAX_LEN = 15,
   localparam int CNT_W  = $clog2(MAX_LEN + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic             clear_i,
   input  byte_kind_e       kind_i,
   input  logic [2:0]       seg_i,
   input  logic [7:0]       byte_i,
   input  logic             m64_i,
   output pfx_state_t       nxt_o,
   output logic [CNT_W-1:0] cnt_o
);

   pfx_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      nxt_o = st_q;
      cnt_o = cnt_q;
      if (take_i && kind_i != K_OPC) begin
         cnt_o = cnt_q + 1'b1;
         if (kind_i != K_REX) begin
            nxt_o.rex_v = 1'b0;
            nxt_o.rex   = 4'h0;
         end
         case (kind_i)
            K_SEG: begin
               if (!m64_i || seg_i == SEG_FS || seg_i == SEG_GS) nxt_o.seg = seg_i;
               if (seg_i == SEG_CS) nxt_o.hint = HINT_NT;
               if (seg_i == SEG_DS) begin
                  nxt_o.hint = HINT_TK;
                  nxt_o.nt   = 1'b1;
               end
            end
            K_OSZ:  nxt_o.osz  = 1'b1;
            K_LOCK: nxt_o.lock = 1'b1;
            K_REP:  nxt_o.rep  = byte_i[0] ? REP_F3 : REP_F2;
            K_REX: begin
               nxt_o.rex_v = 1'b1;
               nxt_o.rex   = byte_i[3:0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         cnt_q <= '0;
      end else if (clear_i) begin
         st_q  <= '0;
         cnt_q <= '0;
      end else if (take_i) begin
         st_q  <= nxt_o;
         cnt_q <= cnt_o;
      end
   end

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(MAX_LEN)) else $error("prefix count reached limit"); // R12

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_q == '0 && st_q == '0)) else $error("state not cleared"); // R2

endmodule

// File: rtl/pfxd_resolve.sv
module pfxd_resolve
   import pfxd_pkg::*;
(
   input  pfx_state_t  st_i,
   input  logic        branch_i,
   output pfx_result_t res_o
);

   logic [3:0] rex_eff;

   always_comb begin
      rex_eff       = st_i.rex_v ? st_i.rex : 4'h0;
      res_o.seg     = st_i.seg;
      res_o.opsz    = st_i.osz;
      res_o.len_chg = st_i.osz & ~rex_eff[3];
      res_o.lock    = st_i.lock;
      res_o.rep     = st_i.rep;
      res_o.rex     = rex_eff;
      res_o.hint_tk = branch_i && st_i.hint == HINT_TK;
      res_o.hint_nt = branch_i && st_i.hint == HINT_NT;
      res_o.notrack = branch_i && st_i.nt;
      if (st_i.rep == REP_F3)      res_o.mp = MP_F3;
      else if (st_i.rep == REP_F2) res_o.mp = st_i.osz ? MP_66F2 : MP_F2;
      else                         res_o.mp = st_i.osz ? MP_66 : MP_NONE;
   end

endmodule

// File: rtl/pfx_front_decoder.sv
module pfx_front_decoder
   import pfxd_pkg::*;
#(
   parameter int MAX_LEN  = 15,
   parameter bit ALLOW_64 = 1'b1,
   localparam int CNT_W   = $clog2(MAX_LEN + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             in_ready,
   input  logic             mode64,
   input  logic             is_branch,
   output logic             out_valid,
   output logic [7:0]       out_opcode,
   output logic [CNT_W-1:0] out_count,
   output logic             out_fault,
   output logic [2:0]       out_seg,
   output logic             out_opsz,
   output logic             out_len_chg,
   output logic             out_lock,
   output logic [1:0]       out_rep,
   output logic [2:0]       out_mp,
   output logic             out_rex_w,
   output logic             out_rex_r,
   output logic             out_rex_x,
   output logic             out_rex_b,
   output logic             out_hint_tk,
   output logic             out_hint_nt,
   output logic             out_notrack
);

   logic             m64_eff;
   logic             take;
   logic             done;
   byte_kind_e       kind;
   logic [2:0]       seg_code;
   pfx_state_t       nxt_st;
   logic [CNT_W-1:0] nxt_cnt;
   pfx_result_t      res;
   pfx_result_t      res_q;
   logic             res_m64_q;

   generate
      if (ALLOW_64) begin : g_m64
         assign m64_eff = mode64;
      end else begin : g_legacy
         logic unused_mode;
         assign unused_mode = mode64;
         assign m64_eff     = 1'b0;
      end
   endgenerate

   assign in_ready = ~out_valid;
   assign take     = in_valid & in_ready;

   pfxd_classify u_cls (
      .byte_i   (in_byte),
      .rex_ok_i (m64_eff),
      .kind_o   (kind),
      .seg_o    (seg_code)
   );

   pfxd_accum #(.MAX_LEN(MAX_LEN)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .clear_i (done),
      .kind_i  (kind),
      .seg_i   (seg_code),
      .byte_i  (in_byte),
      .m64_i   (m64_eff),
      .nxt_o   (nxt_st),
      .cnt_o   (nxt_cnt)
   );

   pfxd_resolve u_res (
      .st_i     (nxt_st),
      .branch_i (is_branch),
      .res_o    (res)
   );

   assign done = take && (kind == K_OPC || nxt_cnt == CNT_W'(MAX_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_opcode <= '0;
         out_count  <= '0;
         out_fault  <= 1'b0;
         res_q      <= '0;
         res_m64_q  <= 1'b0;
      end else begin
         out_valid <= done;
         if (done) begin
            out_opcode <= in_byte;
            out_count  <= nxt_cnt;
            out_fault  <= (kind != K_OPC);
            res_q      <= res;
            res_m64_q  <= m64_eff;
         end
      end
   end

   assign out_seg     = res_q.seg;
   assign out_opsz    = res_q.opsz;
   assign out_len_chg = res_q.len_chg;
   assign out_lock    = res_q.lock;
   assign out_rep     = res_q.rep;
   assign out_mp      = res_q.mp;
   assign out_rex_w   = res_q.rex[3];
   assign out_rex_r   = res_q.rex[2];
   assign out_rex_x   = res_q.rex[1];
   assign out_rex_b   = res_q.rex[0];
   assign out_hint_tk = res_q.hint_tk;
   assign out_hint_nt = res_q.hint_nt;
   assign out_notrack = res_q.notrack;

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid) else $error("result pulse longer than one cycle"); // R1

   AST_SEG_64_ONLY_FSGS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && res_m64_q) |-> (out_seg == SEG_NONE || out_seg == SEG_FS || out_seg == SEG_GS))
      else $error("legacy segment effective in 64-bit mode"); // R4

   AST_NO_REX_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !res_m64_q) |-> !(out_rex_w || out_rex_r || out_rex_x || out_rex_b))
      else $error("REX bits outside 64-bit mode"); // R8

   AST_FAULT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault) |-> out_count == CNT_W'(MAX_LEN))
      else $error("fault at wrong count"); // R12

   AST_LENCHG_IMPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      out_len_chg |-> (out_opsz && !out_rex_w)) else $error("length change without 66h"); // R9

   AST_HINT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_hint_tk, out_hint_nt})) else $error("both hints set"); // R5

   AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !$past(done)) |-> $stable(out_seg)) else $error("fields moved"); // R1

endmodule

// File: tb/pfx_front_decoder_tb_top.sv
module pfx_front_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_ready;
   logic       mode64 = 1'b0;
   logic       is_branch = 1'b0;
   logic       out_valid;
   logic [7:0] out_opcode;
   logic [3:0] out_count;
   logic       out_fault;
   logic [2:0] out_seg;
   logic       out_opsz, out_len_chg, out_lock;
   logic [1:0] out_rep;
   logic [2:0] out_mp;
   logic       out_rex_w, out_rex_r, out_rex_x, out_rex_b;
   logic       out_hint_tk, out_hint_nt, out_notrack;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] pbuf [16];

   always #4 clk = ~clk;

   pfx_front_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .mode64(mode64), .is_branch(is_branch),
      .out_valid(out_valid), .out_opcode(out_opcode), .out_count(out_count),
      .out_fault(out_fault), .out_seg(out_seg), .out_opsz(out_opsz),
      .out_len_chg(out_len_chg), .out_lock(out_lock), .out_rep(out_rep),
      .out_mp(out_mp), .out_rex_w(out_rex_w), .out_rex_r(out_rex_r),
      .out_rex_x(out_rex_x), .out_rex_b(out_rex_b), .out_hint_tk(out_hint_tk),
      .out_hint_nt(out_hint_nt), .out_notrack(out_notrack)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int seg_of(input logic [7:0] b);
      case (b)
         8'h26: return 1; 8'h2E: return 2; 8'h36: return 3;
         8'h3E: return 4; 8'h64: return 5; 8'h65: return 6;
         default: return 0;
      endcase
   endfunction

   function automatic bit is_pfx(input logic [7:0] b, input bit m64);
      if (seg_of(b) != 0) return 1;
      if (b == 8'h66 || b == 8'h67 || b == 8'hF0 || b == 8'hF2 || b == 8'hF3) return 1;
      if (m64 && b[7:4] == 4'h4) return 1;
      return 0;
   endfunction

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(posedge clk);
   endtask

   // Runs pbuf[0..] through the block in the given mode and checks every field.
   task automatic run(input bit m64, input bit br);
      int cnt = 0, seg = 0, hint = 0, rep = 0, rex = 0, last = 0;
      bit nt = 0, osz = 0, lock = 0, rexv = 0, fault = 0;
      int mp, rexe;
      logic [7:0] op = 8'h00;
      for (int i = 0; i < 16; i++) begin
         logic [7:0] b = pbuf[i];
         last = i;
         if (!is_pfx(b, m64)) begin op = b; break; end
         cnt++;
         if (!(m64 && b[7:4] == 4'h4)) begin rexv = 0; rex = 0; end
         if (seg_of(b) != 0) begin
            if (!m64 || seg_of(b) >= 5) seg = seg_of(b);
            if (b == 8'h2E) hint = 1;
            if (b == 8'h3E) begin hint = 2; nt = 1; end
         end
         if (b == 8'h66) osz = 1;
         if (b == 8'hF0) lock = 1;
         if (b == 8'hF3) rep = 1;
         if (b == 8'hF2) rep = 2;
         if (m64 && b[7:4] == 4'h4) begin rexv = 1; rex = b[3:0]; end
         if (cnt == 15) begin fault = 1; op = b; break; end
      end
      rexe = rexv ? rex : 0;
      if (rep == 1) mp = 2;
      else if (rep == 2) mp = osz ? 4 : 3;
      else mp = osz ? 1 : 0;
      mode64 = m64;
      is_branch = br;
      for (int i = 0; i <= last; i++) push(pbuf[i]);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 valid", int'(out_valid), 1);
      chk("R1 ready low", int'(in_ready), 0);
      chk("R2 count", int'(out_count), cnt);
      chk(m64 ? "R2 opcode" : "R8 opcode", int'(out_opcode), int'(op));
      chk("R12 fault", int'(out_fault), int'(fault));
      chk(m64 ? "R4 seg" : "R3 seg", int'(out_seg), seg);
      chk("R5 taken", int'(out_hint_tk), int'(br && hint == 2));
      chk("R5 not taken", int'(out_hint_nt), int'(br && hint == 1));
      chk("R6 notrack", int'(out_notrack), int'(br && nt));
      chk(m64 ? "R7 rex" : "R8 rex",
          int'({out_rex_w, out_rex_r, out_rex_x, out_rex_b}), rexe);
      chk("R9 opsz", int'(out_opsz), int'(osz));
      chk("R9 lenchg", int'(out_len_chg), int'(osz && rexe < 8));
      chk("R10 lock", int'(out_lock), int'(lock));
      chk("R10 rep", int'(out_rep), rep);
      chk("R11 mp", int'(out_mp), mp);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] cand [15] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66,
                                8'h67, 8'hF0, 8'hF2, 8'hF3, 8'h40, 8'h4C, 8'h48, 8'h4F};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R13 valid", int'(out_valid), 0);
      chk("R13 ready", int'(in_ready), 1);
      chk("R13 count", int'(out_count), 0);
      chk("R13 seg", int'(out_seg), 0);
      rst_n = 1'b1;

      // Sweep of every ordered prefix pair ahead of an opcode.
      for (int m = 0; m < 2; m++)
         for (int br = 0; br < 2; br++)
            for (int a = 0; a < 15; a++)
               for (int c = 0; c < 15; c++) begin
                  pbuf[0] = cand[a];
                  pbuf[1] = cand[c];
                  pbuf[2] = 8'h90;
                  run(m[0], br[0]);
               end

      // R4: mixed FS/CS/GS/DS in 64-bit mode must give GS.
      pbuf[0] = 8'h64; pbuf[1] = 8'h2E; pbuf[2] = 8'h65; pbuf[3] = 8'h3E; pbuf[4] = 8'hFF;
      run(1'b1, 1'b1);
      chk("R4 gs wins", int'(out_seg), 6);
      run(1'b0, 1'b0);
      chk("R3 ds wins", int'(out_seg), 4);

      // R1: the pulse drops and fields hold on the next cycle.
      @(negedge clk);
      chk("R1 pulse ends", int'(out_valid), 0);
      chk("R1 ready back", int'(in_ready), 1);
      chk("R1 seg holds", int'(out_seg), 4);

      // R12: 14 prefixes then opcode, and 15 prefixes.
      for (int i = 0; i < 14; i++) pbuf[i] = (i % 2) ? 8'h66 : 8'h48;
      pbuf[14] = 8'h0F;
      run(1'b1, 1'b0);
      chk("R12 fourteen", int'(out_count), 14);
      for (int i = 0; i < 15; i++) pbuf[i] = 8'hF0;
      pbuf[15] = 8'h90;
      run(1'b1, 1'b0);
      chk("R12 fifteen", int'(out_fault), 1);

      // R7: REX then 66 then REX keeps the last REX.
      pbuf[0] = 8'h41; pbuf[1] = 8'h66; pbuf[2] = 8'h4A; pbuf[3] = 8'hC7;
      run(1'b1, 1'b0);
      chk("R7 last rex", int'({out_rex_w, out_rex_r, out_rex_x, out_rex_b}), 4'hA);

      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule